// File: doc/BRIEF.md
# Strobe-Latched 256x4 Static Memory

This block is a synthesizable model of a small static memory of 256 words of 4 bits, with a separate write-data input and a read-data output. An access begins on the falling edge of an active-low chip-enable strobe. That edge captures the address and the first chip-select. The access then runs for as long as the strobe stays low. A write-enable input sets its direction: when low it writes, and when high it reads. The second chip-select is not latched. It is applied live to gate both the access and the output drive.

Read data passes into an output latch, and the latch keeps the last word read after the strobe rises. The output stage does not use a physical three-state pad. It presents the latched word together with a drive-enable, and a bus multiplexer or pad cell outside the block turns that pair into a three-state signal. The storage is a 32 x 32 cell matrix. The upper five address bits pick a row, and the lower three pick one 4-bit group within that row.

The strobe and all other inputs are sampled in a single system clock domain. Strobe edges are detected synchronously, so the model contains only flip-flops.

Top module: `edge_sram`

## Requirements
- R1: While reset is held and after reset, `q_oe` is 0, `q` is 0 and no access is in progress.
- R2: The address and the inverted `sel1_n` are captured at the clock edge where `ce_n` is first seen low after being high. Changes on `addr` during the rest of that access have no effect on the word accessed.
- R3: While an access is in progress, `sel1_n` was low at capture, `sel2_n` is low and `we_n` is 0, the word on `din` is stored at the captured address on every clock edge.
- R4: While an access is in progress, the block is selected as in R3 and `we_n` is 1, `q` shows the word at the captured address from the second clock edge after the strobe falls.
- R5: After an access ends (`ce_n` high), `q` keeps the last word read until another selected read occurs. This holds across writes and deselected accesses.
- R6: `q_oe` is 1 exactly when `sel1_n` was low at the last capture, `sel2_n` is currently low and no write is in progress.
- R7: An access captured with `sel1_n` high changes neither the memory nor `q`, and `q_oe` stays 0 during it.
- R8: While `sel2_n` is high, no write or read takes place and `q_oe` is 0.
- R9: All 256 addresses hold distinct words. Bits 7..3 of the address choose one of 32 rows, and bits 2..0 choose one of 8 four-bit groups in that row.
- R10: During a selected write access `q_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip-enable strobe; its falling edge starts an access |
| sel1_n | input | 1 | Active-low select, latched at the strobe's falling edge |
| sel2_n | input | 1 | Active-low select, applied live to gate the access and the output drive |
| we_n | input | 1 | Direction: 0 writes, 1 reads |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| q | output | 4 | Latched read data |
| q_oe | output | 1 | Drive-enable for the three-state output buffer |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 4-bit word and 5 row bits. With these values the full 256-word space, and therefore every row and column pairing of the 32 x 32 matrix, can be covered with a complete write pass followed by a complete read pass in a few thousand cycles. The same build allows the bench to move the address after capture, to deassert each select on its own, and to hold the strobe high for several cycles. These cases show whether the latched address, the latched and live selects and the holding output latch behave as required.

// File: rtl/esram_pkg.sv
package esram_pkg;

    localparam int DEF_ADDR_W   = 8;
    localparam int DEF_DATA_W   = 4;
    localparam int DEF_ROW_BITS = 5;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_BLOCKED
    } acc_kind_e;

    typedef struct packed {
        logic active;
        logic sel_lat;
    } strobe_state_t;

    function automatic acc_kind_e decode_access(input strobe_state_t st,
                                                input logic sel2_n,
                                                input logic we_n);
        acc_kind_e k;
        if (!st.active)                      k = ACC_IDLE;
        else if (!st.sel_lat || sel2_n)      k = ACC_BLOCKED;
        else if (we_n)                       k = ACC_READ;
        else                                 k = ACC_WRITE;
        return k;
    endfunction

endpackage

// File: rtl/esram_strobe.sv
module esram_strobe
    import esram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              sel1_n,
    input  logic [ADDR_W-1:0] addr,
    output strobe_state_t     st,
    output logic [ADDR_W-1:0] lat_addr
);

    logic ce_d;
    logic fall_edge;
    logic rise_edge;

    assign fall_edge = ce_d && !ce_n;
    assign rise_edge = !ce_d && ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_d       <= 1'b1;
            st.active  <= 1'b0;
            st.sel_lat <= 1'b0;
            lat_addr   <= '0;
        end else begin
            ce_d <= ce_n;
            if (fall_edge) begin
                st.active  <= 1'b1;
                st.sel_lat <= !sel1_n;
                lat_addr   <= addr;
            end else if (rise_edge) begin
                st.active  <= 1'b0;
            end
        end
    end

    // R2: the captured address cannot move while an access is under way
    a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
        (st.active && ce_d == 1'b0) |=> $stable(lat_addr));

    // R2: an access starts only from a strobe falling edge
    a_r2_start_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(st.active) |-> ($past(ce_n) == 1'b0 && ce_d == 1'b0));

endmodule

// File: rtl/esram_array.sv
module esram_array
    import esram_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int ROW_BITS = DEF_ROW_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int COL_BITS = ADDR_W - ROW_BITS;
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int COLS     = 1 << COL_BITS;
    localparam int ROW_W    = COLS * DATA_W;

    logic [ROW_BITS-1:0] row_idx;
    logic [COL_BITS-1:0] col_idx;
    logic [ROW_W-1:0]    row_bus [ROWS];
    logic [ROW_W-1:0]    row_pick;

    assign row_idx = addr[ADDR_W-1 -: ROW_BITS];
    assign col_idx = addr[COL_BITS-1:0];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [ROW_W-1:0] cells;
        logic             row_hit;

        assign row_hit = wr_en && (row_idx == ROW_BITS'(r));

        always_ff @(posedge clk) begin
            if (row_hit) begin
                for (int c = 0; c < COLS; c++) begin
                    if (col_idx == COL_BITS'(c))
                        cells[c*DATA_W +: DATA_W] <= wdata;
                end
            end
        end

        assign row_bus[r] = cells;
    end

    assign row_pick = row_bus[row_idx];
    assign rdata    = row_pick[col_idx*DATA_W +: DATA_W];

    // R3: a written word is visible at the same address on the next cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $stable(addr)) |=> (rdata == $past(wdata)));

endmodule

// File: rtl/esram_out.sv
module esram_out
    import esram_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_e         kind,
    input  logic              sel_lat,
    input  logic              sel2_n,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] q,
    output logic              q_oe
);

    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (kind == ACC_READ)
            hold_q <= rd_word;
    end

    assign q    = hold_q;
    assign q_oe = sel_lat && !sel2_n && (kind != ACC_WRITE);

    // R4: a read cycle leaves the addressed word in the output latch
    a_r4_read_lands: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_READ) |=> (q == $past(rd_word)));

    // R5: outside read cycles the output latch keeps its value
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (kind != ACC_READ) |=> $stable(q));

    // R8: a high second select removes the drive
    a_r8_sel2_off: assert property (@(posedge clk) disable iff (rst)
        sel2_n |-> !q_oe);

endmodule

// File: rtl/edge_sram.sv
module edge_sram
    import esram_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int ROW_BITS = DEF_ROW_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              sel1_n,
    input  logic              sel2_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q,
    output logic              q_oe
);

    strobe_state_t     st;
    logic [ADDR_W-1:0] lat_addr;
    acc_kind_e         kind;
    logic [DATA_W-1:0] rd_word;

    esram_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .sel1_n   (sel1_n),
        .addr     (addr),
        .st       (st),
        .lat_addr (lat_addr)
    );

    assign kind = decode_access(st, sel2_n, we_n);

    esram_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ROW_BITS (ROW_BITS)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .wr_en (kind == ACC_WRITE),
        .addr  (lat_addr),
        .wdata (din),
        .rdata (rd_word)
    );

    esram_out #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .sel_lat (st.sel_lat),
        .sel2_n  (sel2_n),
        .rd_word (rd_word),
        .q       (q),
        .q_oe    (q_oe)
    );

    // R1: the reset state has no drive and a cleared latch
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!q_oe && q == '0));

    // R10: no drive while a selected write is running
    a_r10_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (st.active && st.sel_lat && !sel2_n && !we_n) |-> !q_oe);

    // R7: an access captured with the first select high never drives
    a_r7_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        (st.active && !st.sel_lat) |-> (!q_oe && $stable(q)));

endmodule

// File: tb/test_edge_sram.sv
module test_edge_sram;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce_n = 1'b1;
    logic       sel1_n = 1'b0;
    logic       sel2_n = 1'b0;
    logic       we_n = 1'b1;
    logic [7:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] q;
    logic       q_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [3:0] model_mem [256];
    logic [3:0] last_rd = 4'h0;

    string      tag_q [$];
    logic [3:0] expq_q [$];
    logic       expoe_q [$];
    event       mon_ev;

    always #10 clk = ~clk;

    edge_sram i_edge_sram (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .sel1_n (sel1_n),
        .sel2_n (sel2_n),
        .we_n   (we_n),
        .addr   (addr),
        .din    (din),
        .q      (q),
        .q_oe   (q_oe)
    );

    // monitor: compares each queued expectation against the outputs
    initial begin
        forever begin
            @(mon_ev);
            while (tag_q.size() > 0) begin
                string      t;
                logic [3:0] eq;
                logic       eo;
                t  = tag_q.pop_front();
                eq = expq_q.pop_front();
                eo = expoe_q.pop_front();
                n_checks++;
                if (q !== eq || q_oe !== eo) begin
                    n_fail++;
                    $display("FAIL %s: q=%h q_oe=%b expected q=%h q_oe=%b",
                             t, q, q_oe, eq, eo);
                end
            end
        end
    end

    task automatic expect_now(input string t, input logic [3:0] eq, input logic eo);
        #1;
        tag_q.push_back(t);
        expq_q.push_back(eq);
        expoe_q.push_back(eo);
        -> mon_ev;
        #1;
    endtask

    function automatic logic [3:0] pat(input int a);
        return 4'((a * 7 + (a >> 4) + 3) & 15);
    endfunction

    // one access: strobe low for two cycles, then high for one
    task automatic access(input logic w_n, input logic [7:0] a, input logic [7:0] a_late,
                          input logic [3:0] d, input logic s1n, input logic s2n,
                          input string t_mid, input bit chk_mid);
        logic sel;
        logic exp_oe;
        @(negedge clk);
        addr = a; din = d; we_n = w_n; sel1_n = s1n; sel2_n = s2n; ce_n = 1'b0;
        @(negedge clk);
        addr = a_late;
        @(negedge clk);
        sel = !s1n && !s2n;
        if (sel && w_n) last_rd = model_mem[a];
        if (sel && !w_n) model_mem[a] = d;
        exp_oe = sel && w_n;
        if (chk_mid) expect_now(t_mid, last_rd, exp_oe);
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model_mem[i] = 4'h0;
        repeat (3) @(negedge clk);
        expect_now("R1 during reset", 4'h0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        expect_now("R1 after reset", 4'h0, 1'b0);

        // R3 R9 R10: fill every word, output undriven while writing
        for (int a = 0; a < 256; a++)
            access(1'b0, 8'(a), 8'(a), pat(a), 1'b0, 1'b0, "R10 write no drive", a < 8);

        // R4 R9 R6: read every word back
        for (int a = 0; a < 256; a++)
            access(1'b1, 8'(a), 8'(a), 4'h0, 1'b0, 1'b0, "R4 R9 readback", 1'b1);

        // R5: the latch holds with the strobe idle
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            expect_now("R5 hold idle", last_rd, 1'b1);
        end

        // R2: address moved after capture is ignored
        access(1'b1, 8'd5, 8'd9, 4'h0, 1'b0, 1'b0, "R2 latched address", 1'b1);
        access(1'b1, 8'd200, 8'd17, 4'h0, 1'b0, 1'b0, "R2 latched address", 1'b1);
        access(1'b0, 8'd40, 8'd41, 4'hA, 1'b0, 1'b0, "R2 write latched", 1'b0);
        access(1'b1, 8'd41, 8'd41, 4'h0, 1'b0, 1'b0, "R2 neighbour intact", 1'b1);
        access(1'b1, 8'd40, 8'd40, 4'h0, 1'b0, 1'b0, "R2 write at captured", 1'b1);

        // R5: a write leaves the latched read word in place
        access(1'b0, 8'd77, 8'd77, 4'h3, 1'b0, 1'b0, "R10 write no drive", 1'b1);
        expect_now("R5 hold after write", last_rd, 1'b1);

        // R7: first select high at capture
        access(1'b0, 8'd10, 8'd10, ~pat(10), 1'b1, 1'b0, "R7 no drive", 1'b1);
        expect_now("R7 q unchanged", last_rd, 1'b0);
        access(1'b1, 8'd33, 8'd33, 4'h0, 1'b1, 1'b0, "R7 read blocked", 1'b1);
        access(1'b1, 8'd10, 8'd10, 4'h0, 1'b0, 1'b0, "R7 memory unchanged", 1'b1);

        // R8: second select high blocks both directions
        access(1'b0, 8'd11, 8'd11, ~pat(11), 1'b0, 1'b1, "R8 no drive", 1'b1);
        access(1'b1, 8'd12, 8'd12, 4'h0, 1'b0, 1'b1, "R8 read blocked", 1'b1);
        access(1'b1, 8'd11, 8'd11, 4'h0, 1'b0, 1'b0, "R8 memory unchanged", 1'b1);

        // R6: live second select toggles the drive on held data
        @(negedge clk);
        sel2_n = 1'b1;
        expect_now("R6 drive off", last_rd, 1'b0);
        @(negedge clk);
        sel2_n = 1'b0;
        expect_now("R6 drive on", last_rd, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule